// File: doc/BRIEF.md
# Dual Static/Rate-of-Change Alarm

This block watches a stream of sampled 16-bit measurement words and raises up to two independent alarm flags. Each alarm channel takes its input from a source it picks itself: the angular rate word (raw or filtered), the temperature word, or the status word. It then compares either the sample itself (static mode) or the change across a programmable number of samples (rate-of-change mode) against a signed threshold. The comparison runs in one of two directions, above or below.

Samples arrive with a one-cycle strobe. The flags are recomputed only on that strobe. A channel whose source is turned off drops its flag on the next clock. A single indicator output can be routed to either of two I/O lines, with either polarity, and shows whether any alarm is active. Configuration comes from a 16-bit control word, two thresholds and two look-back depths. These are held steady by the surrounding register logic, which lies outside this block.

Top module: `dual_alarm_monitor`

## Requirements
- R1: After reset both alarm flags are 0 and both indicator lines are 0.
- R2: The channel 1 source code is `ctrlWord[11:8]` and the channel 2 source code is `ctrlWord[15:12]`. Code 1 selects the rate word, code 2 the temperature word and code 3 the status word. Code 0 and codes 4 to 15 disable the channel. A disabled channel's flag is 0 from the clock edge after the code appears, with or without a strobe.
- R3: `ctrlWord[3]` = 1 makes source code 1 read `rateFilt` instead of `rateRaw`. The bit has no effect on the other sources.
- R4: In static mode the sample is compared with the threshold as a signed 16-bit number. The polarity bit is `ctrlWord[4]` for channel 1 and `ctrlWord[5]` for channel 2. Polarity 1 raises the flag when the value is strictly greater than the threshold. Polarity 0 raises it when the value is strictly less. Equality never raises it.
- R5: A flag changes only at a clock edge where `sampleStrobe` is 1, except when a disable clears it. The result appears on `alarmFlags` one clock after the strobe edge. Input changes between strobes have no effect.
- R6: `ctrlWord[6]` (channel 1) and `ctrlWord[7]` (channel 2) select rate-of-change mode. The compared value is the current sample minus the sample taken N strobes earlier. N is the channel's 8-bit depth, and a depth of 0 behaves as 1.
- R7: The rate-of-change difference saturates to the range -32768 to +32767 instead of wrapping.
- R8: In rate-of-change mode the flag stays 0 until N samples of the current source have been recorded. Recording starts at reset or at the most recent change of that channel's source code.
- R9: `alarmFlags[0]` is alarm 1 (status bit 8) and `alarmFlags[1]` is alarm 2 (status bit 9). The two channels work independently.
- R10: The indicator is enabled by `ctrlWord[2]`. `ctrlWord[1]` = 1 makes it active high, and `ctrlWord[0]` selects `indLine[1]` (1) or `indLine[0]` (0). When enabled, the selected line is at the active level while either flag is set and at the inactive level otherwise. The unselected line, and both lines when the indicator is disabled, are 0.
- R11: With control word 0x11AF, channel 1 flags filtered rate below its threshold (static) and channel 2 flags a filtered-rate rise above its threshold (rate-of-change). The indicator drives `indLine[1]` high while either alarm is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | One-cycle strobe marking a new sample set |
| rateRaw | input | 16 | Unfiltered rate sample |
| rateFilt | input | 16 | Filtered rate sample |
| tempWord | input | 16 | Temperature sample |
| statusWord | input | 16 | Status word sample |
| ctrlWord | input | 16 | Alarm control word |
| thresh1 | input | 16 | Channel 1 signed threshold |
| thresh2 | input | 16 | Channel 2 signed threshold |
| depth1 | input | 8 | Channel 1 look-back depth |
| depth2 | input | 8 | Channel 2 look-back depth |
| alarmFlags | output | 2 | Alarm flags (bit 0 = alarm 1, bit 1 = alarm 2) |
| indLine | output | 2 | Indicator I/O lines |

## Verification
A wrong history pointer or a wrong fill count shows up as a rate-of-change flag that fires while the history is still filling, or at the wrong strobe after a depth or source change. Either error appears on `alarmFlags` one clock after the affected strobe. A missing saturation flips the flag at extreme input swings on the first strobe that spans full scale. Indicator routing errors show on `indLine` in the same cycle as the control change, because the indicator is combinational from the flags.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // look-back field width; the history buffer holds 2**LOOK_W samples
  parameter int LOOK_W = 8;

  // control word field positions
  localparam int SRC_LSB  = 8;
  localparam int SRC_W    = 4;
  localparam int DYN_LSB  = 6;
  localparam int POL_LSB  = 4;
  localparam int FILT_BIT = 3;
  localparam int IND_EN   = 2;
  localparam int IND_POL  = 1;
  localparam int IND_SEL  = 0;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF  = 4'd0,
    SRC_RATE = 4'd1,
    SRC_TEMP = 4'd2,
    SRC_STAT = 4'd3
  } srcCode_e;

  typedef enum logic [1:0] {
    PICK_RATE = 2'd0,
    PICK_TEMP = 2'd1,
    PICK_STAT = 2'd2
  } srcPick_e;

  // per-channel command from control to datapath
  typedef struct packed {
    logic              capture;
    logic              enable;
    logic              dynMode;
    logic              above;
    logic              histReady;
    srcPick_e          srcPick;
    logic [LOOK_W-1:0] lookBack;
  } chanCmd_t;

  typedef struct packed {
    logic en;
    logic actHigh;
    logic lineSel;
  } indCfg_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sampleStrobe,
  input  logic [15:0]                   ctrlWord,
  input  logic [NUM_CH-1:0][LOOK_W-1:0] lookDepth,
  output chanCmd_t [NUM_CH-1:0]         chanCmd,
  output logic                          filtPick,
  output indCfg_t                       indCfg
);

  assign filtPick       = ctrlWord[FILT_BIT];
  assign indCfg.en      = ctrlWord[IND_EN];
  assign indCfg.actHigh = ctrlWord[IND_POL];
  assign indCfg.lineSel = ctrlWord[IND_SEL];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SRC_W-1:0]  srcCode;
    logic [SRC_W-1:0]  srcPrev;
    logic              srcChanged;
    logic              srcOn;
    logic [LOOK_W-1:0] fillCnt;
    logic [LOOK_W-1:0] effDepth;
    srcPick_e          pick;

    assign srcCode    = ctrlWord[SRC_LSB + SRC_W*c +: SRC_W];
    assign srcChanged = (srcCode != srcPrev);

    always_comb begin
      srcOn = 1'b0;
      pick  = PICK_RATE;
      case (srcCode)
        SRC_RATE: begin srcOn = 1'b1; pick = PICK_RATE; end
        SRC_TEMP: begin srcOn = 1'b1; pick = PICK_TEMP; end
        SRC_STAT: begin srcOn = 1'b1; pick = PICK_STAT; end
        default:  begin srcOn = 1'b0; pick = PICK_RATE; end
      endcase
    end

    // a depth of zero behaves as one sample
    assign effDepth = (lookDepth[c] == '0) ? LOOK_W'(1) : lookDepth[c];

    // fill count: samples of the current source recorded so far
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        srcPrev <= SRC_OFF;
        fillCnt <= '0;
      end else begin
        srcPrev <= srcCode;
        if (srcChanged)
          fillCnt <= sampleStrobe ? LOOK_W'(1) : '0;
        else if (sampleStrobe && (fillCnt != '1))
          fillCnt <= fillCnt + LOOK_W'(1);
      end
    end

    assign chanCmd[c].capture   = sampleStrobe;
    assign chanCmd[c].enable    = srcOn;
    assign chanCmd[c].dynMode   = ctrlWord[DYN_LSB + c];
    assign chanCmd[c].above     = ctrlWord[POL_LSB + c];
    assign chanCmd[c].histReady = !srcChanged && (fillCnt >= effDepth);
    assign chanCmd[c].srcPick   = pick;
    assign chanCmd[c].lookBack  = effDepth;
  end

endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  chanCmd_t [NUM_CH-1:0]         chanCmd,
  input  logic                          filtPick,
  input  indCfg_t                       indCfg,
  input  logic [DATA_W-1:0]             rateRaw,
  input  logic [DATA_W-1:0]             rateFilt,
  input  logic [DATA_W-1:0]             tempWord,
  input  logic [DATA_W-1:0]             statusWord,
  input  logic [NUM_CH-1:0][DATA_W-1:0] threshVec,
  output logic [NUM_CH-1:0]             alarmFlags,
  output logic [1:0]                    indLine
);

  localparam int HIST_N = 1 << LOOK_W;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] rateSel;
  assign rateSel = filtPick ? rateFilt : rateRaw;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [DATA_W-1:0] curVal;
    logic [DATA_W-1:0] pastVal;
    logic [DATA_W:0]   wideDiff;
    logic [DATA_W-1:0] satDiff;
    logic [DATA_W-1:0] cmpVal;
    logic              hit;
    logic [LOOK_W-1:0] wrPtr;
    logic [LOOK_W-1:0] rdPtr;
    logic [DATA_W-1:0] histMem [HIST_N];
    logic              flagQ;

    always_comb begin
      case (chanCmd[c].srcPick)
        PICK_TEMP: curVal = tempWord;
        PICK_STAT: curVal = statusWord;
        default:   curVal = rateSel;
      endcase
    end

    // history ring: one entry per strobe
    assign rdPtr   = wrPtr - chanCmd[c].lookBack;
    assign pastVal = histMem[rdPtr];

    always_ff @(posedge clk) begin
      if (chanCmd[c].capture)
        histMem[wrPtr] <= curVal;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        wrPtr <= '0;
      else if (chanCmd[c].capture)
        wrPtr <= wrPtr + LOOK_W'(1);
    end

    // saturating signed difference
    assign wideDiff = {curVal[DATA_W-1], curVal} - {pastVal[DATA_W-1], pastVal};

    always_comb begin
      if (wideDiff[DATA_W] != wideDiff[DATA_W-1])
        satDiff = wideDiff[DATA_W] ? MIN_V : MAX_V;
      else
        satDiff = wideDiff[DATA_W-1:0];
    end

    assign cmpVal = chanCmd[c].dynMode ? satDiff : curVal;
    assign hit    = chanCmd[c].above ? ($signed(cmpVal) > $signed(threshVec[c]))
                                     : ($signed(cmpVal) < $signed(threshVec[c]));

    always_ff @(posedge clk) begin
      if (!rst_n)
        flagQ <= 1'b0;
      else if (!chanCmd[c].enable)
        flagQ <= 1'b0;
      else if (chanCmd[c].capture)
        flagQ <= chanCmd[c].dynMode ? (chanCmd[c].histReady && hit) : hit;
    end

    assign alarmFlags[c] = flagQ;
  end

  // indicator routing
  logic anyAlarm;
  logic lineLevel;
  assign anyAlarm  = |alarmFlags;
  assign lineLevel = indCfg.actHigh ? anyAlarm : !anyAlarm;

  always_comb begin
    indLine = 2'b00;
    if (indCfg.en)
      indLine[indCfg.lineSel] = lineLevel;
  end

endmodule

// File: rtl/dual_alarm_monitor.sv
module dual_alarm_monitor
  import alarm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleStrobe,
  input  logic [DATA_W-1:0] rateRaw,
  input  logic [DATA_W-1:0] rateFilt,
  input  logic [DATA_W-1:0] tempWord,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [15:0]       ctrlWord,
  input  logic [DATA_W-1:0] thresh1,
  input  logic [DATA_W-1:0] thresh2,
  input  logic [LOOK_W-1:0] depth1,
  input  logic [LOOK_W-1:0] depth2,
  output logic [1:0]        alarmFlags,
  output logic [1:0]        indLine
);

  localparam int NUM_CH = 2;

  chanCmd_t [NUM_CH-1:0]         chanCmd;
  logic                          filtPick;
  indCfg_t                       indCfg;
  logic [NUM_CH-1:0][DATA_W-1:0] threshVec;
  logic [NUM_CH-1:0][LOOK_W-1:0] depthVec;

  assign threshVec = {thresh2, thresh1};
  assign depthVec  = {depth2, depth1};

  alarm_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampleStrobe (sampleStrobe),
    .ctrlWord     (ctrlWord),
    .lookDepth    (depthVec),
    .chanCmd      (chanCmd),
    .filtPick     (filtPick),
    .indCfg       (indCfg)
  );

  alarm_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chanCmd    (chanCmd),
    .filtPick   (filtPick),
    .indCfg     (indCfg),
    .rateRaw    (rateRaw),
    .rateFilt   (rateFilt),
    .tempWord   (tempWord),
    .statusWord (statusWord),
    .threshVec  (threshVec),
    .alarmFlags (alarmFlags),
    .indLine    (indLine)
  );

endmodule

// File: rtl/alarm_checker.sv
module alarm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sampleStrobe,
  input logic [15:0] tempWord,
  input logic [15:0] ctrlWord,
  input logic [15:0] thresh1,
  input logic [1:0]  alarmFlags,
  input logic [1:0]  indLine
);

  a_r2_off_clears_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord[11:8] == 4'd0) |=> !alarmFlags[0]);

  a_r2_off_clears_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord[15:12] == 4'd0) |=> !alarmFlags[1]);

  a_r5_no_rise_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleStrobe |=> !$rose(alarmFlags[0]));

  a_r5_no_rise_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleStrobe |=> !$rose(alarmFlags[1]));

  a_r4_static_above: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStrobe && ctrlWord[11:8] == 4'd2 && !ctrlWord[6] && ctrlWord[4]
     && ($signed(tempWord) > $signed(thresh1))) |=> alarmFlags[0]);

  a_r10_one_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWord[1] |-> $onehot0(indLine));

  a_r10_quiet_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord[1] && alarmFlags == 2'b00) |-> (indLine == 2'b00));

endmodule

bind dual_alarm_monitor alarm_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sampleStrobe (sampleStrobe),
  .tempWord     (tempWord),
  .ctrlWord     (ctrlWord),
  .thresh1      (thresh1),
  .alarmFlags   (alarmFlags),
  .indLine      (indLine)
);

// File: tb/dual_alarm_monitor_tb_top.sv
module dual_alarm_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] rateRaw = '0;
  logic [15:0] rateFilt = '0;
  logic [15:0] tempWord = '0;
  logic [15:0] statusWord = '0;
  logic [15:0] ctrlWord = '0;
  logic [15:0] thresh1 = '0;
  logic [15:0] thresh2 = '0;
  logic [7:0]  depth1 = '0;
  logic [7:0]  depth2 = '0;
  logic [1:0]  alarmFlags;
  logic [1:0]  indLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_alarm_monitor dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampleStrobe (sampleStrobe),
    .rateRaw      (rateRaw),
    .rateFilt     (rateFilt),
    .tempWord     (tempWord),
    .statusWord   (statusWord),
    .ctrlWord     (ctrlWord),
    .thresh1      (thresh1),
    .thresh2      (thresh2),
    .depth1       (depth1),
    .depth2       (depth2),
    .alarmFlags   (alarmFlags),
    .indLine      (indLine)
  );

  task automatic chkFlags(input string req, input logic [1:0] exp);
    checks++;
    if (alarmFlags !== exp) begin
      errors++;
      $display("FAIL %s flags actual %b expected %b", req, alarmFlags, exp);
    end
  endtask

  task automatic chkInd(input string req, input logic [1:0] exp);
    checks++;
    if (indLine !== exp) begin
      errors++;
      $display("FAIL %s indLine actual %b expected %b", req, indLine, exp);
    end
  endtask

  // one strobed sample; returns at the negedge after the capturing edge
  task automatic pulse(input logic [15:0] r, input logic [15:0] f,
                       input logic [15:0] t, input logic [15:0] s);
    @(negedge clk);
    rateRaw = r; rateFilt = f; tempWord = t; statusWord = s;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  task automatic setCtrl(input logic [15:0] v);
    @(negedge clk);
    ctrlWord = v;
  endtask

  task automatic testReset();
    chkFlags("R1", 2'b00);
    chkInd("R1", 2'b00);
  endtask

  task automatic testStatic();
    thresh1 = 16'd100;
    setCtrl(16'h0210);                       // ch1 temp, above
    pulse(0, 0, 16'd101, 0); chkFlags("R4 above", 2'b01);
    pulse(0, 0, 16'd100, 0); chkFlags("R4 equal", 2'b00);
    pulse(0, 0, 16'hFFFB, 0); chkFlags("R4 signed", 2'b00);
    thresh2 = 16'hFFF6;                      // -10
    setCtrl(16'h3210);                       // ch2 status, below
    pulse(0, 0, 16'd101, 16'hFFF0); chkFlags("R9 both", 2'b11);
    pulse(0, 0, 16'd0, 16'd5); chkFlags("R4 below clear", 2'b00);
  endtask

  task automatic testHold();
    @(negedge clk);
    tempWord = 16'd500; statusWord = 16'hFFF0;
    repeat (3) @(negedge clk);
    chkFlags("R5 no strobe", 2'b00);
    pulse(0, 0, 16'd500, 16'd5); chkFlags("R5 strobe", 2'b01);
  endtask

  task automatic testFilter();
    thresh1 = 16'd500;
    setCtrl(16'h0118);                       // ch1 rate filtered, above
    pulse(16'd1000, 16'd0, 0, 0); chkFlags("R3 filtered", 2'b00);
    setCtrl(16'h0110);
    pulse(16'd1000, 16'd0, 0, 0); chkFlags("R3 raw", 2'b01);
    setCtrl(16'h0218);                       // temp ignores filter bit
    thresh1 = 16'd100;
    pulse(16'd0, 16'd0, 16'd200, 0); chkFlags("R3 temp unaffected", 2'b01);
  endtask

  task automatic testDynamic();
    thresh1 = 16'd50; depth1 = 8'd0;
    setCtrl(16'h0350);                       // ch1 status dynamic above
    setCtrl(16'h0250);                       // ch1 temp dynamic above
    pulse(0, 0, 16'd0, 0);   chkFlags("R8 first", 2'b00);
    pulse(0, 0, 16'd100, 0); chkFlags("R6 depth0", 2'b01);
    pulse(0, 0, 16'd120, 0); chkFlags("R6 small step", 2'b00);
    depth1 = 8'd1;
    pulse(0, 0, 16'd200, 0); chkFlags("R6 depth1", 2'b01);
    depth1 = 8'd3;
    setCtrl(16'h0350);                       // source change restarts history
    pulse(0, 0, 0, 16'd200); chkFlags("R8 fill0", 2'b00);
    pulse(0, 0, 0, 16'd200); chkFlags("R8 fill1", 2'b00);
    pulse(0, 0, 0, 16'd200); chkFlags("R8 fill2", 2'b00);
    pulse(0, 0, 0, 16'd260); chkFlags("R6 depth3 a", 2'b01);
    pulse(0, 0, 0, 16'd260); chkFlags("R6 depth3 b", 2'b01);
    pulse(0, 0, 0, 16'd260); chkFlags("R6 depth3 c", 2'b01);
    pulse(0, 0, 0, 16'd260); chkFlags("R6 depth3 flat", 2'b00);
  endtask

  task automatic testSaturate();
    depth2 = 8'd1; thresh2 = 16'h8001;       // -32767
    setCtrl(16'h3080);                       // ch2 status dynamic below
    pulse(0, 0, 0, 16'h7FFF); chkFlags("R8 ch2 first", 2'b00);
    pulse(0, 0, 0, 16'h8000); chkFlags("R7 negative sat", 2'b10);
    thresh2 = 16'h7FFE;
    setCtrl(16'h30A0);                       // above, same source
    pulse(0, 0, 0, 16'h7FFF); chkFlags("R7 positive sat", 2'b10);
    setCtrl(16'h00A0);                       // disable ch2 without strobe
    @(negedge clk);
    chkFlags("R2 disable clears", 2'b00);
    thresh2 = 16'd0;
    setCtrl(16'h7020);                       // unlisted code 7
    pulse(0, 0, 0, 16'd100); chkFlags("R2 code7 off", 2'b00);
  endtask

  task automatic testIndicator();
    thresh1 = 16'd100;
    setCtrl(16'h0210);
    pulse(0, 0, 16'd200, 0); chkFlags("R10 setup", 2'b01);
    setCtrl(16'h0216); #1; chkInd("R10 line0 high", 2'b01);
    setCtrl(16'h0217); #1; chkInd("R10 line1 high", 2'b10);
    setCtrl(16'h0213); #1; chkInd("R10 disabled", 2'b00);
    setCtrl(16'h0214); #1; chkInd("R10 active low on", 2'b00);
    pulse(0, 0, 16'd0, 0); chkFlags("R10 clear", 2'b00);
    chkInd("R10 active low idle", 2'b01);
  endtask

  task automatic testExample();
    thresh1 = 16'h0FA0; thresh2 = 16'h0FA0; depth2 = 8'd2;
    setCtrl(16'h11AF);
    pulse(0, 16'd0, 0, 0); chkFlags("R11 s0", 2'b01); chkInd("R11 s0", 2'b10);
    pulse(0, 16'd0, 0, 0); chkFlags("R11 s1", 2'b01);
    pulse(0, 16'd5000, 0, 0); chkFlags("R11 s2", 2'b10); chkInd("R11 s2", 2'b10);
    pulse(0, 16'd5000, 0, 0); chkFlags("R11 s3", 2'b10);
    pulse(0, 16'd5000, 0, 0); chkFlags("R11 s4", 2'b00); chkInd("R11 s4", 2'b00);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testStatic();
    testHold();
    testFilter();
    testDynamic();
    testSaturate();
    testIndicator();
    testExample();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish();
  end

endmodule